// File: doc/BRIEF.md
# Block-Copy Engine into Video Memory

This engine copies one contiguous block of bytes from system memory into the video memory window. Software loads a source address and a destination address, one byte at a time, through a small register write port. Writing the control register then stores the written byte and starts the copy. The low seven bits of that byte give the length in 16-byte blocks.

The engine clears the low four bits of both addresses before it starts. It confines the destination to an 8 KiB window that begins at 0x8000. It then reads bytes from system memory in increasing address order, one per cycle, and writes each byte to the matching video address. A busy flag stays high for the whole copy. When the last byte has been written, the busy flag drops and the control register reads 0xFF. Control writes made while busy are ignored. The programmed address registers are never altered by a copy; only internal working counters advance.

System memory is read through a port with a fixed one-cycle latency: the data for a read strobe must be presented on the cycle that follows the strobe. The matching video write appears one cycle after that.

Top module: `vdma_copier`

## Requirements
- R1: After reset, busy, mem_rd_en and vram_we are low, the control register reads 0xFF, and the four address byte registers read 0x00.
- R2: Register select codes are 0 for source high, 1 for source low, 2 for destination high, 3 for destination low and 4 for control. A write stores reg_wdata in the selected register. reg_rdata returns the register chosen by reg_rsel one clock later; codes 5 to 7 read as 0x00.
- R3: The first system memory read of a copy uses the programmed source address with bits 3:0 cleared.
- R4: The first video write of a copy goes to 0x8000 plus the programmed destination, taking bits 12:4 only. Each later write goes to the next address, and the address wraps from 0x9FFF back to 0x8000.
- R5: A copy writes exactly (ctrl[6:0]+1)*16 bytes; bit 7 of the control value has no effect on length.
- R6: Source reads advance by one per byte (wrapping at 0xFFFF). The k-th video write carries the byte that system memory returned for the k-th read.
- R7: A control write while idle stores the written value, which reads back unchanged while the copy runs.
- R8: When a copy completes, busy goes low and the control register reads 0xFF.
- R9: While busy, a control write is ignored: the stored control value, the length and the addresses of the running copy do not change.
- R10: A copy leaves the four programmed address byte registers unchanged.
- R11: Every video write address lies in 0x8000 to 0x9FFF.
- R12: A video write appears exactly two cycles after its read strobe, and no read or write strobe occurs while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_wsel | input | 3 | Register select for writes |
| reg_wdata | input | 8 | Register write data |
| reg_rsel | input | 3 | Register select for reads |
| reg_rdata | output | 8 | Registered read data |
| busy | output | 1 | Copy in progress |
| mem_rd_en | output | 1 | System memory read strobe |
| mem_rd_addr | output | 16 | System memory read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the strobe |
| vram_we | output | 1 | Video memory write strobe |
| vram_addr | output | 16 | Video memory write address |
| vram_wdata | output | 8 | Video memory write data |

## Verification
On every cycle, the assertions check several things. Every video address must stay inside the window. Consecutive reads and writes must step by one, and the window offset must wrap. Each write must follow its read by two cycles, strobes may occur only while busy, and the first read after the start must be aligned. Other behaviours depend on what software programmed, so only the scoreboard scenarios can show them. These are the exact byte count for a control value, the data carried for each byte, the alignment of the programmed addresses, the 0xFF completion value, the rejection of a control write made mid-copy, and the unchanged address registers.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  typedef enum logic [2:0] {
    SEL_SRC_HI = 3'd0,
    SEL_SRC_LO = 3'd1,
    SEL_DST_HI = 3'd2,
    SEL_DST_LO = 3'd3,
    SEL_CTRL   = 3'd4
  } reg_sel_e;

  localparam logic [7:0] CTRL_IDLE = 8'hFF;
endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    wsel,
  input  logic [DW-1:0] wdata,
  input  logic [2:0]    rsel,
  input  logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [DW-1:0] ctrl,
  output logic          busy,
  output logic          start
);
  logic [DW-1:0] src_hi, src_lo, dst_hi, dst_lo, ctrl_q;
  logic          busy_q;

  assign start = we && (wsel == SEL_CTRL) && !busy_q;
  assign src   = {src_hi, src_lo};
  assign dst   = {dst_hi, dst_lo};
  assign ctrl  = ctrl_q;
  assign busy  = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_hi <= '0;
      src_lo <= '0;
      dst_hi <= '0;
      dst_lo <= '0;
      ctrl_q <= DW'(CTRL_IDLE);
      busy_q <= 1'b0;
    end else begin
      if (we) begin
        case (wsel)
          SEL_SRC_HI: src_hi <= wdata;
          SEL_SRC_LO: src_lo <= wdata;
          SEL_DST_HI: dst_hi <= wdata;
          SEL_DST_LO: dst_lo <= wdata;
          default: ;
        endcase
      end
      if (start) begin
        ctrl_q <= wdata;
        busy_q <= 1'b1;
      end else if (done) begin
        ctrl_q <= DW'(CTRL_IDLE);
        busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (rsel)
        SEL_SRC_HI: rdata <= src_hi;
        SEL_SRC_LO: rdata <= src_lo;
        SEL_DST_HI: rdata <= dst_hi;
        SEL_DST_LO: rdata <= dst_lo;
        SEL_CTRL:   rdata <= ctrl_q;
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/vdma_seq.sv
module vdma_seq #(
  parameter int          AW       = 16,
  parameter int          WIN_BITS = 13,
  parameter int          ALIGN    = 4,
  parameter int          LEN_BITS = 7,
  parameter logic [15:0] VBASE    = 16'h8000,
  localparam int         CNT_W    = LEN_BITS + ALIGN + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [AW-1:0]       src,
  input  logic [AW-1:0]       dst,
  input  logic [LEN_BITS-1:0] len_code,
  output logic                rd_en,
  output logic [AW-1:0]       rd_addr,
  output logic [AW-1:0]       tag_addr,
  output logic                tag_last
);
  logic                active;
  logic [AW-1:0]       ptr;
  logic [WIN_BITS-1:0] off;
  logic [CNT_W-1:0]    remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      ptr      <= '0;
      off      <= '0;
      remain   <= '0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      tag_addr <= '0;
      tag_last <= 1'b0;
    end else if (start) begin
      active   <= 1'b1;
      ptr      <= {src[AW-1:ALIGN], {ALIGN{1'b0}}};
      off      <= {dst[WIN_BITS-1:ALIGN], {ALIGN{1'b0}}};
      remain   <= (CNT_W'(len_code) + CNT_W'(1)) << ALIGN;
      rd_en    <= 1'b0;
      tag_last <= 1'b0;
    end else if (active) begin
      rd_en    <= 1'b1;
      rd_addr  <= ptr;
      tag_addr <= AW'(VBASE) + AW'(off);
      tag_last <= (remain == CNT_W'(1));
      ptr      <= ptr + AW'(1);
      off      <= off + WIN_BITS'(1);
      remain   <= remain - CNT_W'(1);
      if (remain == CNT_W'(1)) active <= 1'b0;
    end else begin
      rd_en    <= 1'b0;
      tag_last <= 1'b0;
    end
  end
endmodule

// File: rtl/vdma_wr.sv
module vdma_wr #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] tag_addr,
  input  logic          tag_last,
  input  logic [DW-1:0] rd_data,
  output logic          vram_we,
  output logic [AW-1:0] vram_addr,
  output logic [DW-1:0] vram_wdata,
  output logic          done
);
  logic          v1, l1;
  logic [AW-1:0] a1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1         <= 1'b0;
      l1         <= 1'b0;
      a1         <= '0;
      vram_we    <= 1'b0;
      vram_addr  <= '0;
      vram_wdata <= '0;
      done       <= 1'b0;
    end else begin
      v1         <= rd_en;
      l1         <= rd_en && tag_last;
      a1         <= tag_addr;
      vram_we    <= v1;
      vram_addr  <= a1;
      vram_wdata <= rd_data;
      done       <= v1 && l1;
    end
  end
endmodule

// File: rtl/vdma_copier.sv
module vdma_copier #(
  parameter int          DW       = 8,
  parameter int          WIN_BITS = 13,
  parameter int          ALIGN    = 4,
  parameter int          LEN_BITS = 7,
  parameter logic [15:0] VBASE    = 16'h8000,
  localparam int         AW       = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_wsel,
  input  logic [DW-1:0] reg_wdata,
  input  logic [2:0]    reg_rsel,
  output logic [DW-1:0] reg_rdata,
  output logic          busy,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          vram_we,
  output logic [AW-1:0] vram_addr,
  output logic [DW-1:0] vram_wdata
);
  logic [AW-1:0] src, dst, tag_addr;
  logic [DW-1:0] ctrl;
  logic          start, done, tag_last;

  vdma_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .wsel(reg_wsel), .wdata(reg_wdata),
    .rsel(reg_rsel), .done(done), .rdata(reg_rdata), .src(src), .dst(dst),
    .ctrl(ctrl), .busy(busy), .start(start)
  );

  vdma_seq #(
    .AW(AW), .WIN_BITS(WIN_BITS), .ALIGN(ALIGN), .LEN_BITS(LEN_BITS), .VBASE(VBASE)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .src(src), .dst(dst),
    .len_code(reg_wdata[LEN_BITS-1:0]), .rd_en(mem_rd_en), .rd_addr(mem_rd_addr),
    .tag_addr(tag_addr), .tag_last(tag_last)
  );

  vdma_wr #(.AW(AW), .DW(DW)) u_wr (
    .clk(clk), .rst(rst), .rd_en(mem_rd_en), .tag_addr(tag_addr),
    .tag_last(tag_last), .rd_data(mem_rd_data), .vram_we(vram_we),
    .vram_addr(vram_addr), .vram_wdata(vram_wdata), .done(done)
  );
endmodule

// File: rtl/vdma_copier_chk.sv
module vdma_copier_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        mem_rd_en,
  input logic [15:0] mem_rd_addr,
  input logic        vram_we,
  input logic [15:0] vram_addr
);
  p_window_r11: assert property (@(posedge clk) disable iff (rst)
    vram_we |-> (vram_addr >= 16'h8000 && vram_addr <= 16'h9FFF));

  p_strobe_busy_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en || vram_we) |-> busy);

  p_src_step_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> mem_rd_addr == $past(mem_rd_addr) + 16'd1);

  p_dst_step_r4: assert property (@(posedge clk) disable iff (rst)
    (vram_we && $past(vram_we)) |-> vram_addr[12:0] == $past(vram_addr[12:0]) + 13'd1);

  p_pipe_r12: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> ##1 vram_we);

  p_align_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> (mem_rd_en && mem_rd_addr[3:0] == 4'd0));

  p_quiet_end_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (!mem_rd_en && !vram_we));
endmodule

bind vdma_copier vdma_copier_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .mem_rd_en(mem_rd_en),
  .mem_rd_addr(mem_rd_addr), .vram_we(vram_we), .vram_addr(vram_addr)
);

// File: tb/test_vdma_copier.sv
module test_vdma_copier;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_wsel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [2:0]  reg_rsel = '0;
  logic [7:0]  reg_rdata;
  logic        busy;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = '0;
  logic        vram_we;
  logic [15:0] vram_addr;
  logic [7:0]  vram_wdata;

  int total = 0;
  int bad = 0;
  int writes_seen = 0;
  logic [23:0] exp_q[$];

  vdma_copier i_vdma_copier (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wsel(reg_wsel),
    .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
    .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .vram_we(vram_we), .vram_addr(vram_addr),
    .vram_wdata(vram_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pattern(input logic [15:0] a);
    return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'h5A;
  endfunction

  // system memory model: one-cycle read latency
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= pattern(mem_rd_addr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every video write
  always @(negedge clk) begin
    if (!rst && vram_we) begin
      writes_seen++;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R5 actual=extra write %h expected=none", vram_addr);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        if ({vram_addr, vram_wdata} !== e) begin
          bad++;
          $display("FAIL R6 actual=%h expected=%h", {vram_addr, vram_wdata}, e);
        end
      end
      if (vram_addr < 16'h8000 || vram_addr > 16'h9FFF) begin
        bad++;
        $display("FAIL R11 actual=%h expected=window", vram_addr);
      end
    end
  end

  task automatic wr_reg(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_wsel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] sel, output logic [7:0] val);
    @(negedge clk);
    reg_rsel = sel;
    @(negedge clk);
    val = reg_rdata;
  endtask

  // driver: programs registers, fills the scoreboard, starts the copy
  task automatic start_copy(input logic [15:0] s, input logic [15:0] d, input logic [7:0] c);
    logic [15:0] sp;
    logic [12:0] dp;
    int n;
    wr_reg(3'd0, s[15:8]);
    wr_reg(3'd1, s[7:0]);
    wr_reg(3'd2, d[15:8]);
    wr_reg(3'd3, d[7:0]);
    sp = {s[15:4], 4'h0};
    dp = {d[12:4], 4'h0};
    n = (int'(c[6:0]) + 1) * 16;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back({16'h8000 + {3'b000, dp}, pattern(sp)});
      sp = sp + 16'd1;
      dp = dp + 13'd1;
    end
    writes_seen = 0;
    wr_reg(3'd4, c);
  endtask

  task automatic finish_copy(input logic [15:0] s, input logic [15:0] d, input int n);
    logic [7:0] v;
    int guard;
    guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    check("R8 busy low", {31'd0, busy}, 32'd0);
    check("R5 count", writes_seen, n);
    check("R5 queue empty", exp_q.size(), 0);
    rd_reg(3'd4, v); check("R8 ctrl idle", v, 8'hFF);
    rd_reg(3'd0, v); check("R10 src hi", v, s[15:8]);
    rd_reg(3'd1, v); check("R10 src lo", v, s[7:0]);
    rd_reg(3'd2, v); check("R10 dst hi", v, d[15:8]);
    rd_reg(3'd3, v); check("R10 dst lo", v, d[7:0]);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 busy", {29'd0, busy, mem_rd_en, vram_we}, 32'd0);
    rd_reg(3'd4, v); check("R1 ctrl", v, 8'hFF);
    rd_reg(3'd0, v); check("R1 src hi", v, 8'h00);
    rd_reg(3'd3, v); check("R1 dst lo", v, 8'h00);

    // R2 register write and readback
    wr_reg(3'd1, 8'hA5);
    wr_reg(3'd2, 8'h3C);
    rd_reg(3'd1, v); check("R2 src lo", v, 8'hA5);
    rd_reg(3'd2, v); check("R2 dst hi", v, 8'h3C);
    rd_reg(3'd6, v); check("R2 unused code", v, 8'h00);

    // R3 R4 R6 R7 short copy with unaligned addresses
    start_copy(16'h1234, 16'h0567, 8'h00);
    rd_reg(3'd4, v); check("R7 ctrl stored", v, 8'h00);
    finish_copy(16'h1234, 16'h0567, 16);

    // R4 R5 R6 wraps: bit 7 set, source and destination wrap
    start_copy(16'hFFF5, 16'hFFF8, 8'h83);
    finish_copy(16'hFFF5, 16'hFFF8, 64);

    // R9 maximum length, control write while busy ignored
    start_copy(16'h4000, 16'h2010, 8'h7F);
    repeat (20) @(negedge clk);
    check("R9 busy mid", {31'd0, busy}, 32'd1);
    wr_reg(3'd4, 8'h05);
    rd_reg(3'd4, v); check("R9 ctrl unchanged", v, 8'h7F);
    finish_copy(16'h4000, 16'h2010, 2048);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule